// File: doc/BRIEF.md
# Accumulator ALU with Zero Flag

This block is the arithmetic and logic stage of a small accumulator machine. Operand A always comes from the accumulator. Operand B comes from the internal data bus. A 3-bit operation code selects one of seven operations: add, subtract, decrement, bitwise OR, bitwise invert, shift left by one, and compare. The result is combinational. A write strobe tells the surrounding datapath whether to load the result into the accumulator.

Compare runs the subtract path and discards the difference. Its only effect is on a one-bit zero flag register that sits beside the ALU. That flag loads on the clock edge, and only when the operation is a compare and the flag-write enable is high. The data path is built from narrow slices. Each slice can add, invert or OR. The carry leaves each slice and enters the next one up. A small encoder turns the operation code into the slice controls: the B-side selection, the logic/arithmetic mode and the initial carry.

Top module: `acc_alu8`

## Requirements
- R1: While reset is asserted and after it is released, the zero flag reads 0 until the first compare with the flag-write enable high.
- R2: Operation code 1 (add) gives result = (A + B) mod 256 and raises acc_wr.
- R3: Operation code 2 (subtract) gives result = (A - B) mod 256 and raises acc_wr. The initial slice carry is active only for this code and for compare.
- R4: Operation code 3 (decrement) gives result = (A - 1) mod 256 and raises acc_wr. The value of B has no effect on the result.
- R5: Operation code 4 (OR) gives result = A | B and raises acc_wr.
- R6: Operation code 5 (invert) gives result = ~A and raises acc_wr. The value of B has no effect on the result.
- R7: Operation code 6 (shift left) gives result = {A[6:0], 0}, so bit 7 is lost, and raises acc_wr.
- R8: Operation code 0 (compare) holds acc_wr low. If flag_we is high at a rising clock edge, the zero flag takes 1 when A equals B and 0 otherwise.
- R9: The zero flag keeps its value on any edge where flag_we is low or the operation code is not 0.
- R10: A carry or borrow produced in bits 3:0 reaches bits 7:4 in the same cycle. For example, 0x0F + 0x01 gives 0x10 and 0x10 - 0x01 gives 0x0F.
- R11: Operation code 7 is reserved. It holds acc_wr low, passes A to the result unchanged, and leaves the zero flag alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock; the zero flag loads on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset for the zero flag |
| op | input | 3 | Operation code: 0 compare, 1 add, 2 subtract, 3 decrement, 4 OR, 5 invert, 6 shift left, 7 reserved |
| acc_in | input | 8 | Operand A from the accumulator |
| bus_in | input | 8 | Operand B from the internal bus |
| flag_we | input | 1 | Enables a compare to load the zero flag |
| result | output | 8 | Combinational ALU result |
| acc_wr | output | 1 | High when the result should be written to the accumulator |
| zero_flag | output | 1 | Registered compare outcome, 1 when the operands were equal |

## Verification
Add and subtract are checked over all 65,536 operand pairs. That sweep covers every carry and borrow crossing the slice boundary, so a broken inter-slice carry or a wrong initial carry shows up as results that are off by 16 or off by 1. Compare is checked on equal operands and on operands that differ in a single low bit or in the top bit. A zero detect that looks only at the low slice, or a flag that tracks subtract or the reserved code, therefore leaves a wrong flag behind. Decrement and invert are run with several unrelated B values, and shift left with every A value. This catches a B leak, a wrap error at 0x00, or a shift that rotates bit 7 back into bit 0.

// File: rtl/acc_alu8.sv
module acc_alu8 #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] bus_in,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         acc_wr,
  output logic         zero_flag
);
  localparam int NS = W / SW;

  localparam logic [2:0] OP_CMP = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_DEC = 3'd3,
                         OP_OR  = 3'd4, OP_NOT = 3'd5, OP_SHL = 3'd6, OP_RSV = 3'd7;

  // slice controls: ysel 0=B 1=~B 2=ones 3=A ; lsel 0=OR 1=invert 2=pass
  logic [1:0] ysel, lsel;
  logic       lmode, cin;

  always_comb begin
    ysel = 2'd0; lsel = 2'd2; lmode = 1'b0; cin = 1'b0;
    case (op)
      OP_CMP, OP_SUB: begin ysel = 2'd1; cin = 1'b1; end
      OP_ADD:         ysel = 2'd0;
      OP_DEC:         ysel = 2'd2;
      OP_OR:          begin lmode = 1'b1; lsel = 2'd0; end
      OP_NOT:         begin lmode = 1'b1; lsel = 2'd1; end
      OP_SHL:         ysel = 2'd3;
      default:        begin lmode = 1'b1; lsel = 2'd2; end
    endcase
  end

  logic [NS:0] cy;
  assign cy[0] = cin;

  for (genvar g = 0; g < NS; g++) begin : g_slice
    logic [SW-1:0] x, b, y, lo;
    logic [SW:0]   s;
    assign x = acc_in[g*SW +: SW];
    assign b = bus_in[g*SW +: SW];
    always_comb begin
      case (ysel)
        2'd0:    y = b;
        2'd1:    y = ~b;
        2'd2:    y = '1;
        default: y = x;
      endcase
      case (lsel)
        2'd0:    lo = x | b;
        2'd1:    lo = ~x;
        default: lo = x;
      endcase
    end
    assign s = {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, cy[g]};
    assign cy[g+1] = s[SW];
    assign result[g*SW +: SW] = lmode ? lo : s[SW-1:0];
  end

  assign acc_wr = (op != OP_CMP) && (op != OP_RSV);

  logic diff_zero;
  assign diff_zero = (result == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                         zero_flag <= 1'b0;
    else if (flag_we && op == OP_CMP)   zero_flag <= diff_zero;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !zero_flag);
  assert_add_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ADD |-> result == W'(acc_in + bus_in) && acc_wr);
  assert_sub_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SUB |-> result == W'(acc_in - bus_in));
  assert_shl_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SHL |-> result[0] == 1'b0 && result[W-1:1] == acc_in[W-2:0]);
  assert_cmp_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CMP && flag_we |=> zero_flag == ($past(acc_in) == $past(bus_in)));
  assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CMP |-> !acc_wr);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op == OP_CMP && flag_we) |=> $stable(zero_flag));
  assert_rsv_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_RSV |-> result == acc_in && !acc_wr);
endmodule

// File: tb/tb_acc_alu8.sv
module tb_acc_alu8;
  logic       clk = 1'b0, rst_n = 1'b0, flag_we = 1'b0;
  logic [2:0] op = 3'd1;
  logic [7:0] acc_in = 8'h00, bus_in = 8'h00;
  logic [7:0] result;
  logic       acc_wr, zero_flag;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu8 dut (.clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .bus_in(bus_in),
                .flag_we(flag_we), .result(result), .acc_wr(acc_wr), .zero_flag(zero_flag));

  task automatic chk(input string req, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h (op=%0d A=%0h B=%0h)", req, got, exp, op, acc_in, bus_in);
    end
  endtask

  task automatic comb(input logic [2:0] o, input int a, input int b);
    op = o; acc_in = 8'(a); bus_in = 8'(b); flag_we = 1'b0;
    #1;
  endtask

  task automatic cmp_step(input int a, input int b, input logic we, input logic [2:0] o);
    @(negedge clk);
    op = o; acc_in = 8'(a); bus_in = 8'(b); flag_we = we;
    @(negedge clk);
    flag_we = 1'b0; op = 3'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", zero_flag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", zero_flag, 0);

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        comb(3'd1, a, b);
        chk("R2 add", result, (a + b) & 255);
        if (a == 255 && b == 255) chk("R2 acc_wr", acc_wr, 1);
        comb(3'd2, a, b);
        chk("R3 sub", result, (a - b) & 255);
      end
    comb(3'd2, 0, 0); chk("R3 acc_wr", acc_wr, 1);
    comb(3'd1, 8'h0F, 8'h01); chk("R10 carry", result, 8'h10);
    comb(3'd2, 8'h10, 8'h01); chk("R10 borrow", result, 8'h0F);

    for (int a = 0; a < 256; a++) begin
      comb(3'd3, a, 0);      chk("R4 dec", result, (a - 1) & 255);
      comb(3'd3, a, 255 - a); chk("R4 dec B ignored", result, (a - 1) & 255);
      comb(3'd3, a, 8'hA5);  chk("R4 dec B ignored", result, (a - 1) & 255);
      comb(3'd4, a, 8'h5A);  chk("R5 or", result, a | 8'h5A);
      comb(3'd4, a, a * 7);  chk("R5 or", result, a | ((a * 7) & 255));
      comb(3'd5, a, 0);      chk("R6 not", result, (~a) & 255);
      comb(3'd5, a, 8'hFF);  chk("R6 not B ignored", result, (~a) & 255);
      comb(3'd6, a, 8'h3C);  chk("R7 shl", result, (a << 1) & 255);
      comb(3'd7, a, 8'h99);  chk("R11 pass", result, a);
    end
    comb(3'd3, 0, 0); chk("R4 acc_wr", acc_wr, 1);
    comb(3'd4, 0, 0); chk("R5 acc_wr", acc_wr, 1);
    comb(3'd5, 0, 0); chk("R6 acc_wr", acc_wr, 1);
    comb(3'd6, 0, 0); chk("R7 acc_wr", acc_wr, 1);
    comb(3'd7, 0, 0); chk("R11 acc_wr", acc_wr, 0);
    comb(3'd0, 5, 5); chk("R8 acc_wr", acc_wr, 0);

    for (int a = 0; a < 256; a++) begin
      cmp_step(a, a, 1'b1, 3'd0);              chk("R8 cmp equal", zero_flag, 1);
      cmp_step(a, a ^ 8'h80, 1'b0, 3'd0);      chk("R9 hold we low", zero_flag, 1);
      cmp_step(a, a, 1'b1, 3'd2);              chk("R9 hold sub", zero_flag, 1);
      cmp_step(a, a ^ 8'h01, 1'b1, 3'd0);      chk("R8 cmp low bit", zero_flag, 0);
      cmp_step(a, a, 1'b1, 3'd7);              chk("R11 flag kept", zero_flag, 0);
      cmp_step(a, a ^ 8'h80, 1'b1, 3'd0);      chk("R8 cmp top bit", zero_flag, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule